// File: doc/BRIEF.md
# Weight-Stationary Systolic Multiply Array

This block computes matrix-vector products on an N-by-N grid of multiply-accumulate cells. Every cell keeps one weight in place. An activation vector is applied as one aligned word. The block staggers it internally so that lane k reaches the grid k cycles after lane 0. Each activation then moves one cell to the right per clock. Partial sums move one cell down per clock. The bottom of each column delivers one dot product. A deskew stage realigns the columns, so each result vector appears as one word under a single valid strobe.

Every cell holds two weight banks, an active one and a shadow one. The next weight set can be loaded into the shadow bank, one grid row per cycle, while traffic runs on the active bank. A swap request then exchanges the roles of the two banks. The bank choice is carried alongside each activation through the grid. Vectors that are already inside the array therefore finish on the weights they started with. Vectors are accepted back to back, one per clock.

Top module: `wsa_array`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid` is 0 and every `out_sum` lane is 0.
- R2: For an accepted vector, output lane c equals the sum over rows r of a[r]·W[r][c]. Here a[r] is `in_act[8r+7:8r]` read as unsigned, W[r][c] is the signed 8-bit weight of row r and column c, and lane c is `out_sum[32c+31:32c]` in 32-bit two's complement.
- R3: A vector sampled with `in_valid` high at one rising edge produces `out_valid` high exactly 2N-1 rising edges later, with its sums in the same cycle. Every `out_valid` pulse has a matching earlier input.
- R4: Vectors applied on consecutive cycles come out on consecutive cycles, in the same order, with no gap.
- R5: The extremes cannot wrap. Activations of 255 against weights of -128 on all N rows give exactly -32640·N in every lane.
- R6: Asserting `wl_en` with row index `wl_row` writes `wl_data[8c+7:8c]` into the shadow-bank weight of row `wl_row`, column c. This changes no result of any vector that runs on the active bank.
- R7: A vector applied in the same cycle as `swap` uses the newly activated bank, as do all later vectors. Vectors applied earlier finish on the previous bank even if they are still in flight.
- R8: In cycles with `in_valid` low, `in_act` is ignored. No output strobe results, and `out_sum` reads 0 in every cycle where `out_valid` is low.
- R9: `swap` toggles between the two banks, so a second swap makes the first weight set active again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wl_en | input | 1 | Write one weight row into the shadow bank |
| wl_row | input | clog2(N) | Row index for the weight write |
| wl_data | input | 8·N | Signed weights for that row, column c in byte c |
| swap | input | 1 | Exchange the active and shadow banks from this cycle's vector on |
| in_valid | input | 1 | Activation vector strobe |
| in_act | input | 8·N | Unsigned activations, row k in byte k |
| out_valid | output | 1 | Result vector strobe |
| out_sum | output | 32·N | Signed column sums, column c in lane c |

## Verification
Two functions can fall in the same cycle: streaming on the active bank, and writing the shadow bank or swapping banks. The bench writes a complete second weight set row by row while vectors stream every cycle. It then raises `swap` in the same cycle as a valid vector, while earlier vectors are still crossing the grid. Every result is judged against a behavioural model of the two banks. Vectors that entered before the swap must match the old set. The swap vector and those after it must match the new set, all at the fixed latency.

// File: rtl/wsa_pkg.sv
`timescale 1ns/1ps
package wsa_pkg;
    localparam int ACT_W = 8;
    localparam int WGT_W = 8;
    localparam int SUM_W = 32;

    typedef logic [ACT_W-1:0]        act_t;
    typedef logic signed [WGT_W-1:0] wgt_t;
    typedef logic signed [SUM_W-1:0] sum_t;

    // an activation travelling through the grid together with its bank choice
    typedef struct packed {
        logic bank;
        act_t act;
    } lane_t;

    localparam int LANE_W = $bits(lane_t);

    // largest magnitudes one cell can add in a single step
    localparam int STEP_MAX = (2**ACT_W - 1) * (2**(WGT_W-1) - 1);
    localparam int STEP_MIN = -((2**ACT_W - 1) * (2**(WGT_W-1)));

    // unsigned activation times signed weight, widened before multiplying
    function automatic sum_t mac_term(input act_t a, input wgt_t w);
        sum_t ax;
        sum_t wx;
        ax = sum_t'({1'b0, a});
        wx = sum_t'(w);
        return ax * wx;
    endfunction
endpackage

// File: rtl/wsa_delay.sv
`timescale 1ns/1ps
module wsa_delay #(
    parameter int W = 1,
    parameter int D = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [D];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < D; i++) stg[i] <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < D; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[D-1];
endmodule

// File: rtl/wsa_cell.sv
`timescale 1ns/1ps
module wsa_cell
    import wsa_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  lane_t lane_in,
    input  sum_t  sum_in,
    input  logic  wr_en,
    input  logic  wr_bank,
    input  wgt_t  wr_val,
    output lane_t lane_out,
    output sum_t  sum_out
);
    wgt_t bank_q [2];

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q[0] <= '0;
            bank_q[1] <= '0;
            lane_out  <= '0;
            sum_out   <= '0;
        end else begin
            if (wr_en) bank_q[wr_bank] <= wr_val;
            lane_out <= lane_in;
            sum_out  <= sum_in + mac_term(lane_in.act, bank_q[lane_in.bank]);
        end
    end

    // R2: the step a cell adds to the sum from above stays within one product's range
    p_step_bound_r2: assert property (@(posedge clk) disable iff (rst)
        ((sum_out - $past(sum_in)) >= sum_t'(STEP_MIN)) &&
        ((sum_out - $past(sum_in)) <= sum_t'(STEP_MAX)));
endmodule

// File: rtl/wsa_array.sv
`timescale 1ns/1ps
module wsa_array
    import wsa_pkg::*;
#(
    parameter int  N   = 8,
    localparam int RW  = (N > 1) ? $clog2(N) : 1,
    localparam int LAT = 2 * N - 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wl_en,
    input  logic [RW-1:0]      wl_row,
    input  logic [N*WGT_W-1:0] wl_data,
    input  logic               swap,
    input  logic               in_valid,
    input  logic [N*ACT_W-1:0] in_act,
    output logic               out_valid,
    output logic [N*SUM_W-1:0] out_sum
);
    localparam int CW = $clog2(LAT + 2) + 1;

    // bank selection: toggled by swap, takes effect on this cycle's vector
    logic front_q;
    logic front_nxt;
    assign front_nxt = front_q ^ swap;

    always_ff @(posedge clk) begin
        if (rst) front_q <= 1'b0;
        else     front_q <= front_nxt;
    end

    // input staggering: row r waits r cycles
    lane_t entry    [N];
    lane_t row_lane [N];

    for (genvar r = 0; r < N; r++) begin : g_skew
        assign entry[r].bank = front_nxt;
        assign entry[r].act  = in_valid ? in_act[r*ACT_W +: ACT_W] : '0;
        if (r == 0) begin : g_direct
            assign row_lane[r] = entry[r];
        end else begin : g_delay
            wsa_delay #(.W(LANE_W), .D(r)) u_skew (
                .clk (clk),
                .rst (rst),
                .din (entry[r]),
                .dout(row_lane[r])
            );
        end
    end

    // weight row writes go to the bank that is not active after this cycle
    logic row_hit [N];
    logic wr_bank;
    assign wr_bank = ~front_nxt;

    for (genvar r = 0; r < N; r++) begin : g_hit
        assign row_hit[r] = wl_en && (wl_row == RW'(r));
    end

    // the grid
    lane_t lane_h [N][N];
    sum_t  sum_v  [N+1][N];

    for (genvar c = 0; c < N; c++) begin : g_top
        assign sum_v[0][c] = '0;
    end

    for (genvar r = 0; r < N; r++) begin : g_row
        for (genvar c = 0; c < N; c++) begin : g_col
            lane_t lin;
            if (c == 0) begin : g_left
                assign lin = row_lane[r];
            end else begin : g_inner
                assign lin = lane_h[r][c-1];
            end
            wsa_cell u_cell (
                .clk     (clk),
                .rst     (rst),
                .lane_in (lin),
                .sum_in  (sum_v[r][c]),
                .wr_en   (row_hit[r]),
                .wr_bank (wr_bank),
                .wr_val  (wl_data[c*WGT_W +: WGT_W]),
                .lane_out(lane_h[r][c]),
                .sum_out (sum_v[r+1][c])
            );
        end
    end

    // output realignment: column c waits N-1-c cycles
    for (genvar c = 0; c < N; c++) begin : g_deskew
        if (c == N - 1) begin : g_direct
            assign out_sum[c*SUM_W +: SUM_W] = sum_v[N][c];
        end else begin : g_delay
            wsa_delay #(.W(SUM_W), .D(N - 1 - c)) u_deskew (
                .clk (clk),
                .rst (rst),
                .din (sum_v[N][c]),
                .dout(out_sum[c*SUM_W +: SUM_W])
            );
        end
    end

    // strobe pipeline matching the data path depth
    wsa_delay #(.W(1), .D(LAT)) u_vpipe (
        .clk (clk),
        .rst (rst),
        .din (in_valid),
        .dout(out_valid)
    );

    // count of accepted vectors not yet delivered, kept for the properties below
    logic [CW-1:0] inflight_q;
    always_ff @(posedge clk) begin
        if (rst) inflight_q <= '0;
        else     inflight_q <= inflight_q + CW'(in_valid) - CW'(out_valid);
    end

    // R3: no result strobe without an earlier accepted vector
    p_out_backed_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (inflight_q != '0));

    // R4: the pipe never holds more vectors than its depth
    p_inflight_cap_r4: assert property (@(posedge clk) disable iff (rst)
        inflight_q <= CW'(LAT));

    // R8: idle cycles carry all-zero sums
    p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_sum == '0));
endmodule

// File: tb/wsa_array_test.sv
`timescale 1ns/1ps
module wsa_array_test;
    localparam int N   = 4;
    localparam int RWB = $clog2(N);
    localparam int LAT = 2 * N - 1;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               wl_en = 1'b0;
    logic [RWB-1:0]     wl_row = '0;
    logic [N*8-1:0]     wl_data = '0;
    logic               swap = 1'b0;
    logic               in_valid = 1'b0;
    logic [N*8-1:0]     in_act = '0;
    logic               out_valid;
    logic [N*32-1:0]    out_sum;

    wsa_array #(.N(N)) uut (
        .clk(clk), .rst(rst), .wl_en(wl_en), .wl_row(wl_row), .wl_data(wl_data),
        .swap(swap), .in_valid(in_valid), .in_act(in_act),
        .out_valid(out_valid), .out_sum(out_sum)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // stimulus table: activation vectors, lane k in byte k
    localparam logic [N*8-1:0] ACT_TAB [8] = '{
        32'h00000000, 32'hFFFFFFFF, 32'h01020304, 32'h80FF0011,
        32'h7F7F7F7F, 32'h000000FF, 32'hFF000000, 32'h5A3C9612 };
    // first weight set, one word per row, column c in byte c
    localparam logic [N*8-1:0] WA_TAB [N] = '{
        32'h01FF7F80, 32'h02030405, 32'hFE80017F, 32'h10F0E020 };

    // behavioural two-bank weight model
    logic signed [7:0] wm [2][N][N];
    bit mfront = 1'b0;

    logic [N*32-1:0] q_sum [$];
    int              q_at  [$];
    string           q_tag [$];

    task automatic check(input bit ok, input string tag,
                         input logic [N*32-1:0] act, input logic [N*32-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [N*32-1:0] model(input logic [N*8-1:0] a, input bit bank);
        logic [N*32-1:0] res;
        for (int c = 0; c < N; c++) begin
            int acc;
            acc = 0;
            for (int r = 0; r < N; r++)
                acc += int'(a[r*8 +: 8]) * int'(wm[bank][r][c]);
            res[c*32 +: 32] = acc;
        end
        return res;
    endfunction

    // one clock of stimulus, applied at a falling edge
    task automatic step(input bit v, input logic [N*8-1:0] a, input bit sw,
                        input bit le, input int row, input logic [N*8-1:0] wd,
                        input string tag);
        if (sw) mfront = !mfront;
        if (le) for (int c = 0; c < N; c++) wm[!mfront][row][c] = wd[c*8 +: 8];
        if (v) begin
            q_sum.push_back(model(a, mfront));
            q_at.push_back(cyc);
            q_tag.push_back(tag);
        end
        in_valid = v;
        in_act   = a;
        swap     = sw;
        wl_en    = le;
        wl_row   = RWB'(row);
        wl_data  = wd;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, '0, 0, 0, 0, '0, "");
    endtask

    // result monitor
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                if (q_sum.size() == 0) begin
                    check(0, "R8 unexpected strobe", 1, 0);
                end else begin
                    check(out_sum == q_sum[0], q_tag[0], out_sum, q_sum[0]);
                    check((cyc - q_at[0]) == LAT, "R3 latency",
                          (N*32)'(cyc - q_at[0]), (N*32)'(LAT));
                    void'(q_sum.pop_front());
                    void'(q_at.pop_front());
                    void'(q_tag.pop_front());
                end
            end else if (q_at.size() > 0 && (cyc - q_at[0]) > LAT) begin
                check(0, "R3 missing strobe", 0, 1);
                void'(q_sum.pop_front());
                void'(q_at.pop_front());
                void'(q_tag.pop_front());
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < 2; b++)
            for (int r = 0; r < N; r++)
                for (int c = 0; c < N; c++) wm[b][r][c] = '0;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
        check(out_sum == '0, "R1 sums in reset", out_sum, '0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);
        check(out_sum == '0, "R1 sums after reset", out_sum, '0);

        // first weight set into the shadow bank
        for (int r = 0; r < N; r++) step(0, '0, 0, 1, r, WA_TAB[r], "");
        // R7: swap together with a valid vector
        step(1, ACT_TAB[2], 1, 0, 0, '0, "R7 swap vector");
        // R4: table walked back to back
        for (int i = 0; i < 8; i++) step(1, ACT_TAB[i], 0, 0, 0, '0, "R4 stream");
        // R6: second set (all -128) written while vectors stream on the active bank
        for (int i = 0; i < 8; i++)
            step(1, ACT_TAB[7-i], 0, (i < N), i % N, 32'h80808080, "R6 load during stream");
        // R5: extremes on the swap cycle, R7: earlier vectors still in flight keep old set
        step(1, 32'hFFFFFFFF, 1, 0, 0, '0, "R5 extreme swap vector");
        step(1, 32'hFFFFFFFF, 0, 0, 0, '0, "R7 after swap");
        check(model(32'hFFFFFFFF, mfront) == {N{32'hFFFE0200}}, "R5 model",
              model(32'hFFFFFFFF, mfront), {N{32'hFFFE0200}});

        // R8: garbage while invalid
        for (int i = 0; i < LAT + 3; i++) begin
            step(0, 32'hDEADBEEF, 0, 0, 0, '0, "");
            if (i >= LAT) begin
                check(out_valid == 1'b0, "R8 idle strobe", out_valid, 0);
                check(out_sum == '0, "R8 idle sums", out_sum, '0);
            end
        end

        // R9: second swap brings the first set back
        step(1, ACT_TAB[3], 1, 0, 0, '0, "R9 toggle back");
        step(1, ACT_TAB[7], 0, 0, 0, '0, "R9 toggle back");
        idle(LAT);

        // R2: random weights with forced extremes, random activations and gaps
        for (int r = 0; r < N; r++) begin
            logic [N*8-1:0] wd;
            for (int c = 0; c < N; c++)
                wd[c*8 +: 8] = ((r + c) % 3 == 0) ? 8'h80 : 8'($urandom_range(0, 255));
            step(0, '0, 0, 1, r, wd, "");
        end
        step(1, 32'hFF00FF00, 1, 0, 0, '0, "R2 random set");
        for (int i = 0; i < 24; i++) begin
            logic [N*8-1:0] a;
            for (int k = 0; k < N; k++)
                a[k*8 +: 8] = (i % 5 == 0) ? 8'hFF : 8'($urandom_range(0, 255));
            step((i % 7) != 3, a, 0, 0, 0, '0, "R2 random");
        end

        idle(LAT + 3);
        check(q_sum.size() == 0, "R3 all delivered", (N*32)'(q_sum.size()), '0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule